// File: doc/BRIEF.md
# Serial Audio Transmit Slot Shifter

This block serializes audio words for a synchronous serial port. A host writes 24-bit words into a holding register. Each word is left-aligned, so a short sample sits in the upper bits. At the start of each transmit slot the block copies the held word into a shift register. It then sends one bit on the serial data output at every bit-clock tick for as long as the frame sync stays high.

The host selects two things through a 5-bit configuration. The low three bits set the data word length, from 8 to 24 bits in steps of 4. The upper two bits choose how long the slot is compared with the word. When the slot is longer than the word, the extra bit times carry zeros. A separate input picks whether the most significant or the least significant bit of the word goes out first.

At each load the block raises a one-cycle strobe so the host can supply the next word. The block also reports whether the word just loaded was new or a repeat of the previous one.

Top module: `tx_slot_shifter`

## Requirements
- R1: After synchronous reset, `sdo`, `empty_pulse` and `underrun` are 0, and the holding register contains 0.
- R2: On a tick (`bclk_en`=1) with `fsync`=0, `sdo` becomes 0 and any slot in progress is abandoned. The next tick with `fsync`=1 then starts a fresh slot.
- R3: With `lsb_first`=0 the word goes out starting at register bit 23 and moves downward, one bit per tick.
- R4: With `lsb_first`=1 the word goes out starting at register bit 24−W and moves upward to bit 23, where W is the word length.
- R5: The word length W comes from `slot_cfg[2:0]`: codes 0, 1, 2, 3, 4 give 8, 12, 16, 20, 24 bits, and codes 5 to 7 give 24 bits.
- R6: The slot length comes from `slot_cfg[4:3]`: 0 gives W, 1 gives 24, and 2 or 3 give 32. Bit times after the first W of the slot send 0.
- R7: A slot starts on a tick with `fsync`=1 when no slot is running or the previous slot has sent all of its bits. While `fsync` stays high, slots follow one another with no gap.
- R8: `empty_pulse` is high for exactly one clock cycle, in the cycle after each slot-start tick, and is low at all other times.
- R9: At each slot start, `underrun` is set to 1 if no host write happened since the previous slot start, and to 0 otherwise. In the underrun case the last written word is sent again. `underrun` changes at no other time.
- R10: A host write in the same cycle as a slot-start tick is used for that slot, and it counts as fresh data.
- R11: Word length, slot length and bit order are captured at slot start. Changing `slot_cfg` or `lsb_first` during a slot does not alter the bits of that slot.
- R12: `sdo` changes only in the cycle after a tick and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Bit-clock tick, one cycle wide |
| fsync | input | 1 | Frame sync level; slots run while high |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 24 | Left-aligned word to transmit |
| slot_cfg | input | 5 | [2:0] word length code, [4:3] slot padding mode |
| lsb_first | input | 1 | 1 sends least significant data bit first |
| sdo | output | 1 | Serial data out, registered |
| empty_pulse | output | 1 | One-cycle strobe after each load |
| underrun | output | 1 | 1 when the current slot repeats stale data |

## Verification
The bench builds the block with its default parameters: a 24-bit register, a 32-bit maximum slot, a minimum word of 8 bits and a step of 4. With these values every word-length code can be reached, including the three codes above the largest legal word. Each padding mode can also be reached, including a 32-bit slot that sends 8 zero bits after a full-width word. A scoreboard model predicts every tick independently of the design. This makes it possible to test back-to-back slots, frames aborted by a dropped frame sync, writes that land on the load tick, and configuration changes in the middle of a slot, all against the same expected bit stream.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  // Width of the slot configuration field and of its word-length part.
  localparam int unsigned CFG_W  = 5;
  localparam int unsigned CODE_W = 3;

  // Slot padding mode carried in the upper configuration bits.
  typedef enum logic [1:0] {
    PAD_EXACT     = 2'd0,  // slot equals the word length
    PAD_TO_REG    = 2'd1,  // slot equals the data register width
    PAD_TO_SLOT   = 2'd2,  // slot equals the maximum slot width
    PAD_TO_SLOT_B = 2'd3   // same as PAD_TO_SLOT
  } pad_mode_e;
endpackage

// File: rtl/tx_slot_len_dec.sv
module tx_slot_len_dec
  import tx_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned MIN_W  = 8,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned LEN_W  = 6
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [LEN_W-1:0] word_len,
  output logic [LEN_W-1:0] slot_len
);
  localparam int unsigned MAX_CODE = (DATA_W - MIN_W) / STEP_W;

  logic [CODE_W-1:0] code;
  pad_mode_e         pad;

  always_comb begin
    code = cfg[CODE_W-1:0];
    pad  = pad_mode_e'(cfg[CFG_W-1:CODE_W]);

    // Out-of-range codes fall back to the full register width.
    if (int'(code) <= int'(MAX_CODE)) begin
      word_len = LEN_W'(MIN_W + STEP_W * int'(code));
    end else begin
      word_len = LEN_W'(DATA_W);
    end

    unique case (pad)
      PAD_EXACT:  slot_len = word_len;
      PAD_TO_REG: slot_len = LEN_W'(DATA_W);
      default:    slot_len = LEN_W'(SLOT_W);
    endcase
  end
endmodule

// File: rtl/tx_slot_hold.sv
module tx_slot_hold #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] load_word,
  output logic              load_fresh
);
  logic [DATA_W-1:0] hold_q;
  logic              fresh_q;

  // A write landing on the load cycle bypasses straight into the shifter.
  always_comb begin
    load_word  = wr_en ? wr_data : hold_q;
    load_fresh = wr_en | fresh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_q <= wr_data;
      end
      if (load) begin
        fresh_q <= 1'b0;
      end else if (wr_en) begin
        fresh_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_slot_serializer.sv
module tx_slot_serializer #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fsync,
  input  logic [DATA_W-1:0] load_word,
  input  logic              load_fresh,
  input  logic [LEN_W-1:0]  word_len_in,
  input  logic [LEN_W-1:0]  slot_len_in,
  input  logic              lsb_in,
  output logic              load,
  output logic              sdo,
  output logic              empty_pulse,
  output logic              underrun
);
  localparam logic [LEN_W-1:0] REG_LEN = LEN_W'(DATA_W);

  logic [LEN_W-1:0]  bit_cnt;
  logic [LEN_W-1:0]  slot_len_q;
  logic              lsb_q;
  logic [SLOT_W-1:0] sr;

  logic [SLOT_W-1:0] word_ext;   // word in the low bits of a slot-wide vector
  logic [SLOT_W-1:0] word_top;   // word in the high bits of a slot-wide vector
  logic [SLOT_W-1:0] img_msb;
  logic [SLOT_W-1:0] img_lsb;
  logic              first_bit;

  // Place the register into a slot-wide vector; no padding bits when equal.
  generate
    if (SLOT_W > DATA_W) begin : g_pad
      assign word_ext = {{(SLOT_W-DATA_W){1'b0}}, load_word};
      assign word_top = {load_word, {(SLOT_W-DATA_W){1'b0}}};
    end else begin : g_nopad
      assign word_ext = load_word;
      assign word_top = load_word;
    end
  endgenerate

  assign load = tick && fsync && ((bit_cnt == '0) || (bit_cnt == slot_len_q));

  always_comb begin
    // MSB-first: keep the upper word_len bits, send from the top.
    img_msb   = word_top & ~({SLOT_W{1'b1}} >> word_len_in);
    // LSB-first: right-justify the word, keep word_len bits, send from bit 0.
    img_lsb   = (word_ext >> (REG_LEN - word_len_in)) &
                ~({SLOT_W{1'b1}} << word_len_in);
    first_bit = lsb_in ? img_lsb[0] : img_msb[SLOT_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt     <= '0;
      slot_len_q  <= '0;
      lsb_q       <= 1'b0;
      sr          <= '0;
      sdo         <= 1'b0;
      empty_pulse <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      empty_pulse <= 1'b0;
      if (tick) begin
        if (!fsync) begin
          bit_cnt <= '0;
          sr      <= '0;
          sdo     <= 1'b0;
        end else if (load) begin
          slot_len_q  <= slot_len_in;
          lsb_q       <= lsb_in;
          sr          <= lsb_in ? (img_lsb >> 1) : (img_msb << 1);
          sdo         <= first_bit;
          bit_cnt     <= LEN_W'(1);
          empty_pulse <= 1'b1;
          underrun    <= ~load_fresh;
        end else begin
          sdo     <= lsb_q ? sr[0] : sr[SLOT_W-1];
          sr      <= lsb_q ? (sr >> 1) : (sr << 1);
          bit_cnt <= bit_cnt + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tx_slot_shifter.sv
module tx_slot_shifter
  import tx_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned MIN_W  = 8,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_en,
  input  logic              fsync,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CFG_W-1:0]  slot_cfg,
  input  logic              lsb_first,
  output logic              sdo,
  output logic              empty_pulse,
  output logic              underrun
);
  localparam int unsigned LEN_W = $clog2(SLOT_W + 1);

  logic [LEN_W-1:0]  word_len;
  logic [LEN_W-1:0]  slot_len;
  logic [DATA_W-1:0] load_word;
  logic              load_fresh;
  logic              load;

  tx_slot_len_dec #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .MIN_W(MIN_W),
    .STEP_W(STEP_W), .LEN_W(LEN_W)
  ) u_dec (
    .cfg      (slot_cfg),
    .word_len (word_len),
    .slot_len (slot_len)
  );

  tx_slot_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .load       (load),
    .load_word  (load_word),
    .load_fresh (load_fresh)
  );

  tx_slot_serializer #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)
  ) u_ser (
    .clk         (clk),
    .rst         (rst),
    .tick        (bclk_en),
    .fsync       (fsync),
    .load_word   (load_word),
    .load_fresh  (load_fresh),
    .word_len_in (word_len),
    .slot_len_in (slot_len),
    .lsb_in      (lsb_first),
    .load        (load),
    .sdo         (sdo),
    .empty_pulse (empty_pulse),
    .underrun    (underrun)
  );
endmodule

// File: rtl/tx_slot_shifter_chk.sv
module tx_slot_shifter_chk (
  input logic clk,
  input logic rst,
  input logic bclk_en,
  input logic fsync,
  input logic sdo,
  input logic empty_pulse,
  input logic underrun
);
  // R2: a tick without frame sync forces the line low.
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    (bclk_en && !fsync) |=> !sdo);

  // R8: the load strobe never lasts two cycles.
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    empty_pulse |=> !empty_pulse);

  // R7: a load strobe is always caused by a tick with frame sync high.
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
    empty_pulse |-> $past(bclk_en && fsync));

  // R12: no tick in the previous cycle means the line held its value.
  assert_hold_between_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(bclk_en) |-> $stable(sdo));

  // R9: the underrun flag moves only together with a load strobe.
  assert_urun_at_load_R9: assert property (@(posedge clk) disable iff (rst)
    !empty_pulse |-> $stable(underrun));
endmodule

bind tx_slot_shifter tx_slot_shifter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bclk_en     (bclk_en),
  .fsync       (fsync),
  .sdo         (sdo),
  .empty_pulse (empty_pulse),
  .underrun    (underrun)
);

// File: tb/tx_slot_shifter_bench.sv
module tx_slot_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_en = 1'b0;
  logic        fsync = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [4:0]  slot_cfg = '0;
  logic        lsb_first = 1'b0;
  logic        sdo, empty_pulse, underrun;

  always #10 clk = ~clk;  // 50 MHz

  tx_slot_shifter u_tx_slot_shifter (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .fsync(fsync),
    .wr_en(wr_en), .wr_data(wr_data), .slot_cfg(slot_cfg),
    .lsb_first(lsb_first), .sdo(sdo), .empty_pulse(empty_pulse),
    .underrun(underrun)
  );

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    logic  bit_v;
    logic  emp;
    logic  ur;
    string req;
  } exp_t;
  exp_t  expq[$];
  exp_t  mon_e;
  string cur_req = "R1";

  // Reference model state.
  logic [23:0] m_hold = '0;
  logic        m_fresh = 1'b0;
  logic [23:0] m_word = '0;
  int          m_wl = 0, m_slot = 0, m_idx = 0;
  logic        m_lsb = 1'b0;
  logic        m_urun = 1'b0;

  function automatic int dec_wl(logic [4:0] c);
    return (c[2:0] <= 3'd4) ? 8 + 4 * int'(c[2:0]) : 24;
  endfunction

  function automatic int dec_slot(logic [4:0] c);
    if (c[4:3] == 2'd0) return dec_wl(c);
    if (c[4:3] == 2'd1) return 24;
    return 32;
  endfunction

  function automatic logic exp_bit(logic [23:0] w, int wl, logic lsb, int p);
    if (p >= wl) return 1'b0;
    return lsb ? w[24 - wl + p] : w[23 - p];
  endfunction

  // Driver: predict one tick, queue the prediction, then drive it.
  task automatic tk(input logic fs, input logic wr, input logic [23:0] wd);
    exp_t e;
    if (wr) begin
      m_hold  = wd;
      m_fresh = 1'b1;
    end
    e.req = cur_req;
    if (!fs) begin
      m_idx = 0;
      e.bit_v = 1'b0; e.emp = 1'b0; e.ur = m_urun;
    end else if (m_idx == 0 || m_idx == m_slot) begin
      m_urun  = !m_fresh;
      m_fresh = 1'b0;
      m_word  = m_hold;
      m_wl    = dec_wl(slot_cfg);
      m_slot  = dec_slot(slot_cfg);
      m_lsb   = lsb_first;
      e.bit_v = exp_bit(m_word, m_wl, m_lsb, 0);
      e.emp = 1'b1; e.ur = m_urun;
      m_idx = 1;
    end else begin
      e.bit_v = exp_bit(m_word, m_wl, m_lsb, m_idx);
      e.emp = 1'b0; e.ur = m_urun;
      m_idx = m_idx + 1;
    end
    expq.push_back(e);
    @(negedge clk);
    fsync   = fs;
    bclk_en = 1'b1;
    wr_en   = wr;
    wr_data = wd;
    @(negedge clk);
    bclk_en = 1'b0;
    wr_en   = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hwrite(input logic [23:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    m_hold  = d;
    m_fresh = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic slot(input int n);
    for (int i = 0; i < n; i++) tk(1'b1, 1'b0, 24'h0);
  endtask

  // Monitor: compare after every tick edge, check quiet cycles otherwise.
  logic tick_d = 1'b0;
  logic last_sdo = 1'b0;
  always @(posedge clk) tick_d <= bclk_en;

  always @(negedge clk) begin
    if (!rst) begin
      if (tick_d) begin
        vectors++;
        if (expq.size() == 0) begin
          miscompares++;
          $display("FAIL R7 unexpected tick actual=tick expected=none");
        end else begin
          mon_e = expq.pop_front();
          if (sdo !== mon_e.bit_v || empty_pulse !== mon_e.emp ||
              underrun !== mon_e.ur) begin
            miscompares++;
            $display("FAIL %s sdo/empty/underrun actual=%b%b%b expected=%b%b%b",
                     mon_e.req, sdo, empty_pulse, underrun,
                     mon_e.bit_v, mon_e.emp, mon_e.ur);
          end
        end
      end else begin
        vectors++;
        if (sdo !== last_sdo || empty_pulse !== 1'b0) begin
          miscompares++;
          $display("FAIL R12 R8 quiet cycle sdo/empty actual=%b%b expected=%b0",
                   sdo, empty_pulse, last_sdo);
        end
      end
    end
    last_sdo = sdo;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    vectors++;
    if (sdo !== 1'b0 || empty_pulse !== 1'b0 || underrun !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset outputs actual=%b%b%b expected=000",
               sdo, empty_pulse, underrun);
    end
    rst = 1'b0;
    @(negedge clk);

    // R2: ticks with frame sync low
    cur_req = "R2";
    tk(1'b0, 1'b0, 24'h0); tk(1'b0, 1'b0, 24'h0);

    // R9 R1: no write since reset, 8-bit exact slot repeats the reset word
    cur_req = "R9"; slot_cfg = 5'b00_000; lsb_first = 1'b0;
    slot(8);
    tk(1'b0, 1'b0, 24'h0);

    // R3 R6 R7: MSB first, 24-bit word in 32-bit slot, back-to-back slots
    cur_req = "R3";
    hwrite(24'hA5C3E1);
    slot_cfg = 5'b10_100;
    slot(30);
    hwrite(24'h3C9A5F);
    slot(2);
    cur_req = "R7";
    slot(32);
    tk(1'b0, 1'b0, 24'h0);

    // R4 R6: LSB first, 12-bit word padded to 24
    cur_req = "R4"; lsb_first = 1'b1; slot_cfg = 5'b01_001;
    hwrite(24'h9F1234);
    slot(24);
    tk(1'b0, 1'b0, 24'h0);

    // R5: every word-length code, exact slot, alternating order
    cur_req = "R5";
    for (int c = 0; c < 8; c++) begin
      slot_cfg  = {2'b00, 3'(c)};
      lsb_first = c[0];
      hwrite(24'hD2B4F1 ^ (24'h13579B * (c + 1)));
      slot(dec_slot(slot_cfg));
    end
    tk(1'b0, 1'b0, 24'h0);

    // R6: 20-bit word in a 32-bit slot (mode 3)
    cur_req = "R6"; slot_cfg = 5'b11_011; lsb_first = 1'b0;
    hwrite(24'hFFFFFF);
    slot(32);
    tk(1'b0, 1'b0, 24'h0);

    // R9: no new write, stale word resent with underrun
    cur_req = "R9";
    slot(32);
    tk(1'b0, 1'b0, 24'h0);

    // R10: write on the load tick itself
    cur_req = "R10"; slot_cfg = 5'b00_010; lsb_first = 1'b1;
    tk(1'b1, 1'b1, 24'h5AC396);
    slot(15);
    tk(1'b0, 1'b0, 24'h0);

    // R11: change configuration mid-slot
    cur_req = "R11"; slot_cfg = 5'b00_010; lsb_first = 1'b0;
    hwrite(24'hC0FFEE);
    slot(5);
    slot_cfg = 5'b10_100; lsb_first = 1'b1;
    slot(11);
    hwrite(24'h81422F);
    slot(32);
    tk(1'b0, 1'b0, 24'h0);

    // R2: drop frame sync mid-slot, then restart
    cur_req = "R2"; slot_cfg = 5'b01_100; lsb_first = 1'b0;
    hwrite(24'h6B1D07);
    slot(5);
    tk(1'b0, 1'b0, 24'h0);
    hwrite(24'h0F0F0F);
    slot(24);
    tk(1'b0, 1'b0, 24'h0);

    repeat (4) @(negedge clk);
    if (expq.size() != 0) begin
      miscompares++;
      $display("FAIL R7 pending predictions actual=%0d expected=0", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule